// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the front end of a byte-wide asynchronous NOR flash. It watches the chip-enable, output-enable and write-enable strobes on a parallel bus. It decodes each command byte written to it, and the last accepted command decides what a read returns: stored bytes, identification codes or the status byte. The storage is a small behavioural array held in registers. It is split into equal blocks, and each block has a fixed lock state.

A block erase takes two writes: a setup byte, then a confirm byte at an address inside the target block. After a fixed number of clock cycles the erase has set every byte of that block to FFh. The controller shows the erase in progress on a ready/busy pin and in the top bit of the status byte. Failure flags in the status byte stay set until a dedicated clear command is written. The status byte is captured at the start of each read access, so a host must end an access and start a new one to see an updated value.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode and `readyBusy` is 1. `dataOut` is 00h whenever no read is active. The array holds the byte (address XOR 5Ah) at every address.
- R2: A command is taken in the cycle where `weN` is first sampled low while `ceN` is low. A read is active while `ceN` and `oeN` are both low.
- R3: Command FFh selects array-read mode. Reads then return the stored byte at `addr`.
- R4: Command 90h selects identifier mode. Address 0 reads 89h and address 1 reads `DEVICE_CODE`. Address 3 reads the master lock on bit 0. Any other address whose in-block offset is 2 reads that block's lock bit on bit 0 (1 = locked). Every other bit reads as 0.
- R5: Command 70h selects status mode. The status byte is: bit 7 ready (1 = idle), bit 5 erase error, bit 4 sequence error, bit 1 locked-block error, all other bits 0.
- R6: In status mode the value shown is the one captured when a read becomes active. It does not change while that read stays active, even if the state underneath changes.
- R7: Writing 20h and then D0h to an unlocked block sets all bytes of that block to FFh and leaves other blocks unchanged. `readyBusy` is 0 for exactly `ERASE_CYCLES` clock cycles, starting in the cycle after the confirm write.
- R8: The controller switches to status mode as soon as the setup byte 20h is accepted, and it stays in status mode after the second write.
- R9: While an erase is running, every write is ignored, including FFh. Reads keep returning status.
- R10: If the write after 20h is not D0h, bits 5 and 4 are set and no data changes.
- R11: If the confirm D0h targets a locked block, bits 5 and 1 are set, no erase starts, and `readyBusy` stays 1.
- R12: Bits 5, 4 and 1 stay set until command 50h clears them. Command 50h leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Command byte |
| dataOut | output | 8 | Read data, 00h when no read is active |
| readyBusy | output | 1 | 1 when idle, 0 while an erase runs |

## Verification
A wrong read mode shows up at the first read after the command that caused it, because the array, identifier and status sources return values that differ from one another. A miscounted erase timer moves the rising edge of `readyBusy`, and the bench measures that edge to the exact cycle. A status flag that was lost or wrongly cleared is visible at the next read access. An erase that hits the wrong block shows up when neighbouring bytes are read back.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_ID, MODE_STATUS} readMode_t;

  typedef struct packed {
    logic eraseDone;
    logic setSeqErr;
    logic setLockErr;
    logic clearErr;
  } dpStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BLK_IDX_W    = 4,
  parameter int ERASE_CYCLES = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrStrobe,
  input  logic [7:0]           cmdData,
  input  logic [BLK_IDX_W-1:0] cmdBlock,
  input  logic                 addrLocked,
  output readMode_t            mode,
  output logic                 busy,
  output logic [BLK_IDX_W-1:0] eraseBlock,
  output dpStrobe_t            strobe
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic             setupSeen;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode       <= MODE_ARRAY;
      setupSeen  <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      eraseBlock <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (wrStrobe) begin
      if (setupSeen) begin
        setupSeen <= 1'b0;
        mode      <= MODE_STATUS;
        if (cmdData == CMD_ERASE_GO && !addrLocked) begin
          busy       <= 1'b1;
          cnt        <= CNT_W'(ERASE_CYCLES - 1);
          eraseBlock <= cmdBlock;
        end
      end else begin
        case (cmdData)
          CMD_READ_ARRAY: mode <= MODE_ARRAY;
          CMD_READ_ID:    mode <= MODE_ID;
          CMD_READ_STAT:  mode <= MODE_STATUS;
          CMD_ERASE_SET: begin
            setupSeen <= 1'b1;
            mode      <= MODE_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.eraseDone  = busy && (cnt == '0);
    strobe.setSeqErr  = !busy && wrStrobe && setupSeen && (cmdData != CMD_ERASE_GO);
    strobe.setLockErr = !busy && wrStrobe && setupSeen && (cmdData == CMD_ERASE_GO) && addrLocked;
    strobe.clearErr   = !busy && wrStrobe && !setupSeen && (cmdData == CMD_CLEAR_STAT);
  end

  // R9: a write during an erase leaves the controller in status mode
  a_r9_busy_ignores_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrStrobe) |=> (mode == MODE_STATUS));
  // R7: the erase timer never exceeds its configured length
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < CNT_W'(ERASE_CYCLES)));
  // R11: a locked-block error never starts an erase
  a_r11_locked_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setLockErr |=> !busy);
  // R8: an accepted setup byte moves reads to status
  a_r8_setup_status: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrStrobe && !setupSeen && cmdData == CMD_ERASE_SET) |=> (mode == MODE_STATUS));
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          BLOCK_W     = 4,
  parameter logic [7:0]  DEVICE_CODE = 8'hAA,
  parameter logic [63:0] LOCK_MASK   = 64'h4,
  parameter logic        MASTER_LOCK = 1'b1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  readMode_t                   mode,
  input  logic                        busy,
  input  logic [ADDR_W-BLOCK_W-1:0]   eraseBlock,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        readActive,
  output logic                        addrLocked,
  output logic [7:0]                  dataOut
);
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int BLOCK_BYTES = 1 << BLOCK_W;

  logic [7:0] mem [DEPTH];
  logic       errErase, errSeq, errLock;
  logic       readActQ;
  logic [7:0] statusLatch, liveStatus, idData;
  logic [ADDR_W-1:0] eraseBase;

  assign eraseBase  = {eraseBlock, {BLOCK_W{1'b0}}};
  assign addrLocked = LOCK_MASK[addr[ADDR_W-1:BLOCK_W]];
  assign liveStatus = {~busy, 1'b0, errErase, errSeq, 2'b00, errLock, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (strobe.eraseDone) begin
      for (int j = 0; j < BLOCK_BYTES; j++)
        mem[{eraseBlock, BLOCK_W'(j)}] <= 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errErase    <= 1'b0;
      errSeq      <= 1'b0;
      errLock     <= 1'b0;
      readActQ    <= 1'b0;
      statusLatch <= '0;
    end else begin
      readActQ <= readActive;
      if (readActive && !readActQ) statusLatch <= liveStatus;
      if (strobe.clearErr) begin
        errErase <= 1'b0;
        errSeq   <= 1'b0;
        errLock  <= 1'b0;
      end else begin
        if (strobe.setSeqErr)  begin errErase <= 1'b1; errSeq  <= 1'b1; end
        if (strobe.setLockErr) begin errErase <= 1'b1; errLock <= 1'b1; end
      end
    end
  end

  always_comb begin
    if (addr == ADDR_W'(0))      idData = 8'h89;
    else if (addr == ADDR_W'(1)) idData = DEVICE_CODE;
    else if (addr == ADDR_W'(3)) idData = {7'b0, MASTER_LOCK};
    else if (addr[BLOCK_W-1:0] == BLOCK_W'(2)) idData = {7'b0, addrLocked};
    else                         idData = 8'h00;
  end

  always_comb begin
    dataOut = 8'h00;
    if (readActive) begin
      case (mode)
        MODE_ARRAY:  dataOut = mem[addr];
        MODE_ID:     dataOut = idData;
        MODE_STATUS: dataOut = statusLatch;
        default:     dataOut = 8'h00;
      endcase
    end
  end

  // R12: error flags hold until the clear strobe
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errErase && !strobe.clearErr) |=> errErase);
  // R7: a finished erase leaves FFh at the block base
  a_r7_erased: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseDone |=> (mem[$past(eraseBase)] == 8'hFF));
  // R6: the shown status is frozen while a read stays active
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (readActive && readActQ) |=> $stable(statusLatch) || !$past(readActQ));
  // R10: a sequence error always carries the erase error flag
  a_r10_seq_pair: assert property (@(posedge clk) disable iff (!rstN)
    errSeq |-> errErase);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          BLOCK_W      = 4,
  parameter int          ERASE_CYCLES = 12,
  parameter logic [7:0]  DEVICE_CODE  = 8'hAA,
  parameter logic [63:0] LOCK_MASK    = 64'h4,
  parameter logic        MASTER_LOCK  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              readyBusy
);
  localparam int BLK_IDX_W = ADDR_W - BLOCK_W;

  logic                 weNq, wrStrobe, readActive, addrLocked, busy;
  readMode_t            mode;
  dpStrobe_t            strobe;
  logic [BLK_IDX_W-1:0] eraseBlock;

  always_ff @(posedge clk) begin
    if (!rstN) weNq <= 1'b1;
    else       weNq <= weN;
  end

  assign wrStrobe   = !ceN && !weN && weNq;
  assign readActive = !ceN && !oeN;
  assign readyBusy  = ~busy;

  flash_cmd_fsm #(.BLK_IDX_W(BLK_IDX_W), .ERASE_CYCLES(ERASE_CYCLES)) u_fsm (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .cmdData(dataIn),
    .cmdBlock(addr[ADDR_W-1:BLOCK_W]), .addrLocked(addrLocked),
    .mode(mode), .busy(busy), .eraseBlock(eraseBlock), .strobe(strobe));

  flash_cmd_dp #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .DEVICE_CODE(DEVICE_CODE),
                 .LOCK_MASK(LOCK_MASK), .MASTER_LOCK(MASTER_LOCK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .busy(busy),
    .eraseBlock(eraseBlock), .addr(addr), .readActive(readActive),
    .addrLocked(addrLocked), .dataOut(dataOut));

  // R2: one command per write-enable fall
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
  localparam int ERASE_N = 12;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [7:0] addr = '0, dataIn = '0;
  logic [7:0] dataOut;
  logic readyBusy;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ERASE_CYCLES(ERASE_N)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .readyBusy(readyBusy));

  // {isWrite, addr, data, expected}
  localparam logic [24:0] VEC [12] = '{
    {1'b0, 8'h00, 8'h00, 8'h5A}, {1'b0, 8'h13, 8'h00, 8'h49},
    {1'b1, 8'h00, 8'h90, 8'h00}, {1'b0, 8'h00, 8'h00, 8'h89},
    {1'b0, 8'h01, 8'h00, 8'hAA}, {1'b0, 8'h02, 8'h00, 8'h00},
    {1'b0, 8'h22, 8'h00, 8'h01}, {1'b0, 8'h03, 8'h00, 8'h01},
    {1'b1, 8'h00, 8'h70, 8'h00}, {1'b0, 8'h00, 8'h00, 8'h80},
    {1'b1, 8'h00, 8'hFF, 8'h00}, {1'b0, 8'h13, 8'h00, 8'h49}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; dataIn = d; ceN = 0; weN = 0;
    @(negedge clk); weN = 1; ceN = 1;
    @(negedge clk);
  endtask

  task automatic busRead(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ceN = 0; oeN = 0;
    @(negedge clk); d = dataOut; oeN = 1; ceN = 1;
    @(negedge clk);
  endtask

  task automatic readCheck(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 readyBusy at reset", {7'b0, readyBusy}, 8'h01);
    check("R1 idle dataOut", dataOut, 8'h00);
    rstN = 1;

    // R3 R4 R5 table walk
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][24]) busWrite(VEC[i][23:16], VEC[i][15:8]);
      else readCheck($sformatf("R3 R4 R5 vector %0d", i), VEC[i][23:16], VEC[i][7:0]);
    end

    // R7: erase block 1, measure busy length
    busWrite(8'h15, 8'h20);
    busWrite(8'h15, 8'hD0);
    cnt = 1;
    for (int g = 0; g < 100 && !readyBusy; g++) begin cnt++; @(negedge clk); end
    check("R7 busy cycles", 8'(cnt), 8'(ERASE_N));
    readCheck("R8 status after erase", 8'h00, 8'h80);
    busWrite(8'h00, 8'hFF);
    readCheck("R7 erased low", 8'h10, 8'hFF);
    readCheck("R7 erased mid", 8'h15, 8'hFF);
    readCheck("R7 erased high", 8'h1F, 8'hFF);
    readCheck("R7 neighbour below", 8'h0F, 8'h55);
    readCheck("R7 neighbour above", 8'h20, 8'h7A);

    // R9 and R6: writes ignored while busy, status frozen during an open read
    busWrite(8'h30, 8'h20);
    busWrite(8'h30, 8'hD0);
    busWrite(8'h00, 8'hFF);
    readCheck("R9 FFh ignored while busy", 8'h00, 8'h00);
    @(negedge clk); ceN = 0; oeN = 0;
    for (int g = 0; g < 100 && !readyBusy; g++) @(negedge clk);
    @(negedge clk);
    check("R6 held during open read", dataOut, 8'h00);
    oeN = 1;
    @(negedge clk); oeN = 0;
    @(negedge clk);
    check("R6 updated on new read", dataOut, 8'h80);
    oeN = 1; ceN = 1;
    busWrite(8'h00, 8'hFF);
    readCheck("R7 block 3 erased", 8'h3A, 8'hFF);
    readCheck("R7 block 2 intact", 8'h2F, 8'h75);

    // R10 bad confirm, R12 sticky and clear
    busWrite(8'h40, 8'h20);
    readCheck("R8 status after setup", 8'h00, 8'h80);
    busWrite(8'h40, 8'h40);
    readCheck("R10 sequence error", 8'h00, 8'hB0);
    busWrite(8'h00, 8'hFF);
    readCheck("R10 no data change", 8'h40, 8'h1A);
    busWrite(8'h00, 8'h70);
    readCheck("R12 flags still set", 8'h00, 8'hB0);
    busWrite(8'h00, 8'h50);
    readCheck("R12 cleared, mode kept", 8'h00, 8'h80);

    // R11 locked block
    busWrite(8'h25, 8'h20);
    busWrite(8'h25, 8'hD0);
    check("R11 no busy", {7'b0, readyBusy}, 8'h01);
    readCheck("R11 lock error", 8'h00, 8'hA2);
    busWrite(8'h00, 8'hFF);
    readCheck("R11 data kept", 8'h25, 8'h7F);

    finish_run();
  end
endmodule